// File: doc/BRIEF.md
# Busy and Total Cycle Counter Bank

A bank of hardware activity counters, configured and read through a plain 32-bit register port that completes every access in one cycle. Each slot counts clock cycles in one of two ways. It can count every clock, which gives a total-time reference. It can instead count only the clocks in which at least one engine selected by its source mask reports busy. Software runs one slot of each kind over a sampling window. It reads both counts, divides busy by total to get a utilisation figure, and then clears both counters for the next window.

Counters saturate at their all-ones value rather than wrap. The designated total slot (slot 0 by default) drives a sticky status bit when its count climbs to its threshold. Software leaves that threshold at its maximum, so the bit reports that the sampling window ran too long. The bit is mirrored on `irq_o` and is cleared by writing one to it.

Top module: `act_counter_bank`

## Requirements
- R1: After reset every count reads 0, every control reads 0 (stopped), every source mask reads 0, every threshold reads the all-ones counter value (0x3FF when CNT_W is 10), and the status bit and `irq_o` are 0.
- R2: With control mode field (bits 1:0) equal to 3, a slot's count rises by exactly one on each clock edge after the edge that wrote the mode.
- R3: With mode 2, a slot's count rises on an edge only when the bitwise AND of its source mask and `busy_i` is nonzero; busy sources outside the mask are ignored.
- R4: Modes 0 and 1 hold the count unchanged.
- R5: Control bit 2 is a filter flag that is stored and read back but has no effect on counting; control bits 31:3 are not stored and read as 0.
- R6: A count read returns the count in bits CNT_W-1:0, and every bit above reads 0.
- R7: A write to a count register with bit 31 set makes the count 0 on that edge; a count write with bit 31 clear leaves the count unchanged.
- R8: When a clearing count write and an increment fall on the same edge, the count becomes 0.
- R9: A count that reaches its all-ones value stays there while counting continues.
- R10: The status bit (read at 0x300 bit 0, and on `irq_o`) sets on the edge where the total slot's count steps up to equal its threshold; no other slot affects it.
- R11: Writing 1 to status bit 0 clears the bit, and writing 0 leaves it set; if a threshold hit and a clearing write fall on the same edge, the bit stays set.
- R12: Address map, byte addresses: slot s occupies 16*s with the mask at +0x0, the count at +0x4 and the control at +0x8. The threshold of slot s sits at 0x200 + 4*s. The status register is at 0x300. Thresholds keep bits CNT_W-1:0. Every other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 10 | Register byte address |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, combinational |
| busy_i | input | NUM_SRC | Per-engine busy indications |
| irq_o | output | 1 | Sticky threshold status bit |

## Verification
Every register is readable, so a wrong mode, mask or threshold appears on `rd_data_o` in the same cycle that its address is presented. A counter that miscounts by even one edge shows up in the next count read, because the bench stops counters at known edges and compares exact values. A status bit that is set or cleared on the wrong edge shows up on `irq_o` one cycle later. The bench therefore samples it on both sides of the hit edge. Saturation is exercised with a narrow counter width so that the all-ones value is reached in about a thousand cycles.

// File: rtl/act_cnt_pkg.sv
package act_cnt_pkg;

    localparam int ADDR_W  = 10;
    localparam int CLR_BIT = 31;

    localparam logic [1:0] MODE_ALWAYS = 2'b11;
    localparam logic [1:0] MODE_BUSY   = 2'b10;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_SLOT = 2'd1,
        RG_THR  = 2'd2,
        RG_STAT = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        FLD_MASK  = 2'd0,
        FLD_COUNT = 2'd1,
        FLD_CTRL  = 2'd2,
        FLD_RSVD  = 2'd3
    } field_e;

    typedef struct packed {
        logic       filt;
        logic [1:0] mode;
    } ctrl_t;

    typedef struct packed {
        region_e    region;
        field_e     field;
        logic [4:0] idx;
    } dec_t;

    // Split a byte address into region, slot index and register field.
    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.region = RG_NONE;
        d.field  = field_e'(a[3:2]);
        d.idx    = '0;
        if (a[1:0] == 2'b00) begin
            case (a[9:8])
                2'b00: begin
                    d.region = RG_SLOT;
                    d.idx    = {1'b0, a[7:4]};
                end
                2'b10: if (a[7] == 1'b0) begin
                    d.region = RG_THR;
                    d.idx    = a[6:2];
                end
                2'b11: if (a[7:2] == 6'd0) d.region = RG_STAT;
                default: ;
            endcase
        end
        return d;
    endfunction

    // Whether a slot advances this cycle, given its mode and masked busy.
    function automatic logic mode_active(input ctrl_t c, input logic any_busy);
        return (c.mode == MODE_ALWAYS) || ((c.mode == MODE_BUSY) && any_busy);
    endfunction

endpackage

// File: rtl/act_slot.sv
module act_slot
    import act_cnt_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int CNT_W   = 31
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] busy_i,
    input  logic               wr_ctrl_i,
    input  logic               wr_mask_i,
    input  logic               wr_thr_i,
    input  logic               wr_cnt_i,
    input  logic [31:0]        wdata_i,
    output ctrl_t              ctrl_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [CNT_W-1:0]   thr_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               reach_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    ctrl_t              ctrl_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [CNT_W-1:0]   thr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               any_busy;
    logic               inc;
    logic               clr;

    assign any_busy = |(mask_q & busy_i);
    assign inc      = mode_active(ctrl_q, any_busy) && (cnt_q != CNT_MAX);
    assign clr      = wr_cnt_i && wdata_i[CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '0;
            thr_q  <= CNT_MAX;
            cnt_q  <= '0;
        end else begin
            if (wr_ctrl_i) ctrl_q <= ctrl_t'(wdata_i[2:0]);
            if (wr_mask_i) mask_q <= wdata_i[NUM_SRC-1:0];
            if (wr_thr_i)  thr_q  <= wdata_i[CNT_W-1:0];
            if (clr)       cnt_q  <= '0;
            else if (inc)  cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign reach_o = inc && !clr && ((cnt_q + 1'b1) == thr_q);
    assign ctrl_o  = ctrl_q;
    assign mask_o  = mask_q;
    assign thr_o   = thr_q;
    assign cnt_o   = cnt_q;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0)); // R8
    AST_SATURATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX)); // R9
    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.mode[1] && !clr) |=> $stable(cnt_q)); // R4
    AST_GATED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode == MODE_BUSY && !any_busy && !clr) |=> $stable(cnt_q)); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt_q != CNT_MAX) |=>
        ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1))); // R2

endmodule

// File: rtl/act_irq_status.sv
module act_irq_status (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic stat_o
);

    logic stat_q;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= 1'b0;
        else     stat_q <= set_i || (stat_q && !clr_i);
    end

    assign stat_o = stat_q;

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> stat_o); // R11
    AST_HOLD_UNCLEARED: assert property (@(posedge clk) disable iff (rst)
        (stat_o && !clr_i) |=> stat_o); // R11
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!stat_o && !set_i) |=> !stat_o); // R10

endmodule

// File: rtl/act_counter_bank.sv
module act_counter_bank
    import act_cnt_pkg::*;
#(
    parameter int NUM_SLOTS  = 8,
    parameter int NUM_SRC    = 32,
    parameter int CNT_W      = 31,
    parameter int TOTAL_SLOT = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic [31:0]        wr_data_i,
    output logic [31:0]        rd_data_o,
    input  logic [NUM_SRC-1:0] busy_i,
    output logic               irq_o
);

    localparam int         SLOT_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam logic [4:0] SLOTS_L = 5'(NUM_SLOTS);

    dec_t                dec;
    logic                idx_ok;
    logic                slot_sel;
    logic                thr_sel;
    logic [SLOT_W-1:0]   sel;
    logic                stat;
    logic                stat_clr;

    ctrl_t               ctrl_a [NUM_SLOTS];
    logic [NUM_SRC-1:0]  mask_a [NUM_SLOTS];
    logic [CNT_W-1:0]    thr_a  [NUM_SLOTS];
    logic [CNT_W-1:0]    cnt_a  [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] reach_a;

    assign dec      = decode_addr(addr_i);
    assign idx_ok   = dec.idx < SLOTS_L;
    assign sel      = dec.idx[SLOT_W-1:0];
    assign slot_sel = (dec.region == RG_SLOT) && idx_ok && (dec.field != FLD_RSVD);
    assign thr_sel  = (dec.region == RG_THR) && idx_ok;
    assign stat_clr = wr_en_i && (dec.region == RG_STAT) && wr_data_i[0];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic hit;
        assign hit = (dec.idx == 5'(s));
        act_slot #(
            .NUM_SRC (NUM_SRC),
            .CNT_W   (CNT_W)
        ) i_slot (
            .clk       (clk),
            .rst       (rst),
            .busy_i    (busy_i),
            .wr_ctrl_i (wr_en_i && slot_sel && hit && dec.field == FLD_CTRL),
            .wr_mask_i (wr_en_i && slot_sel && hit && dec.field == FLD_MASK),
            .wr_thr_i  (wr_en_i && thr_sel && hit),
            .wr_cnt_i  (wr_en_i && slot_sel && hit && dec.field == FLD_COUNT),
            .wdata_i   (wr_data_i),
            .ctrl_o    (ctrl_a[s]),
            .mask_o    (mask_a[s]),
            .thr_o     (thr_a[s]),
            .cnt_o     (cnt_a[s]),
            .reach_o   (reach_a[s])
        );
    end

    act_irq_status i_status (
        .clk    (clk),
        .rst    (rst),
        .set_i  (reach_a[TOTAL_SLOT]),
        .clr_i  (stat_clr),
        .stat_o (stat)
    );

    always_comb begin
        rd_data_o = '0;
        case (dec.region)
            RG_SLOT: if (idx_ok) begin
                case (dec.field)
                    FLD_MASK:  rd_data_o = 32'(mask_a[sel]);
                    FLD_COUNT: rd_data_o = 32'(cnt_a[sel]);
                    FLD_CTRL:  rd_data_o = {29'd0, ctrl_a[sel]};
                    default:   rd_data_o = '0;
                endcase
            end
            RG_THR:  if (idx_ok) rd_data_o = 32'(thr_a[sel]);
            RG_STAT: rd_data_o = {31'd0, stat};
            default: rd_data_o = '0;
        endcase
    end

    assign irq_o = stat;

    AST_COUNT_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (dec.region == RG_SLOT && dec.field == FLD_COUNT) |->
        (rd_data_o[31:CNT_W] == '0)); // R6
    AST_STATUS_READ: assert property (@(posedge clk) disable iff (rst)
        (dec.region == RG_STAT) |-> (rd_data_o[0] == irq_o)); // R10

endmodule

// File: tb/test_act_counter_bank.sv
module test_act_counter_bank;

    localparam int CNT_W   = 10;
    localparam int NUM_SRC = 32;
    localparam logic [31:0] CMAX = 32'h3FF;
    localparam logic [31:0] CLR  = 32'h8000_0000;
    localparam logic [9:0]  STAT = 10'h300;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [9:0]         addr = '0;
    logic               wr_en = 1'b0;
    logic [31:0]        wdata = '0;
    logic [31:0]        rdata;
    logic [NUM_SRC-1:0] busy = '0;
    logic               irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    act_counter_bank #(
        .NUM_SLOTS  (8),
        .NUM_SRC    (NUM_SRC),
        .CNT_W      (CNT_W),
        .TOTAL_SLOT (0)
    ) i_act_counter_bank (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wr_data_i (wdata),
        .rd_data_o (rdata),
        .busy_i    (busy),
        .irq_o     (irq)
    );

    function automatic logic [9:0] a_mask(int s);  return 10'(s * 16);          endfunction
    function automatic logic [9:0] a_cnt(int s);   return 10'(s * 16 + 4);      endfunction
    function automatic logic [9:0] a_ctrl(int s);  return 10'(s * 16 + 8);      endfunction
    function automatic logic [9:0] a_thr(int s);   return 10'(32'h200 + s * 4); endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; the next rising edge captures the write.
    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl", a_ctrl(3), 32'd0);
        rd_chk("R1 mask", a_mask(5), 32'd0);
        rd_chk("R1 thr",  a_thr(7),  CMAX);
        rd_chk("R1 count", a_cnt(0), 32'd0);
        rd_chk("R1 status", STAT, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_always();
        wr(a_ctrl(6), 32'd3);
        repeat (9) @(negedge clk);
        wr(a_ctrl(6), 32'd0);
        rd_chk("R2 always count", a_cnt(6), 32'd10);
        repeat (3) @(negedge clk);
        rd_chk("R4 held after stop", a_cnt(6), 32'd10);
    endtask

    task automatic t_busy();
        wr(a_mask(4), (32'd1 << 21) | 32'd1);
        wr(a_ctrl(4), 32'd2);
        busy = NUM_SRC'(32'd1 << 21);
        repeat (5) @(negedge clk);
        rd_chk("R3 masked bit 21", a_cnt(4), 32'd5);
        busy = NUM_SRC'(32'd1 << 3);
        repeat (4) @(negedge clk);
        rd_chk("R3 unmasked ignored", a_cnt(4), 32'd5);
        busy = NUM_SRC'(32'd1);
        repeat (3) @(negedge clk);
        busy = '0;
        repeat (2) @(negedge clk);
        wr(a_ctrl(4), 32'd0);
        rd_chk("R3 gated total", a_cnt(4), 32'd8);
    endtask

    task automatic t_stopped();
        wr(a_ctrl(3), 32'd1);
        repeat (10) @(negedge clk);
        rd_chk("R4 mode 1", a_cnt(3), 32'd0);
        rd_chk("R4 mode 0", a_cnt(5), 32'd0);
    endtask

    task automatic t_filter();
        wr(a_ctrl(2), 32'hFFFF_FFFF);
        rd_chk("R5 ctrl readback", a_ctrl(2), 32'd7);
        repeat (4) @(negedge clk);
        wr(a_ctrl(2), 32'd4);
        rd_chk("R5 filter ignored", a_cnt(2), 32'd5);
        rd_chk("R5 filter stored", a_ctrl(2), 32'd4);
        repeat (3) @(negedge clk);
        rd_chk("R5 filter stopped", a_cnt(2), 32'd5);
    endtask

    task automatic t_clear();
        wr(a_cnt(6), 32'd5);
        rd_chk("R7 write without bit 31", a_cnt(6), 32'd10);
        wr(a_cnt(6), CLR);
        rd_chk("R7 clear", a_cnt(6), 32'd0);
        wr(a_ctrl(6), 32'd3);
        repeat (3) @(negedge clk);
        rd_chk("R8 before clear", a_cnt(6), 32'd3);
        wr(a_cnt(6), CLR);
        rd_chk("R8 clear beats increment", a_cnt(6), 32'd0);
        wr(a_ctrl(6), 32'd0);
    endtask

    task automatic t_saturate();
        wr(a_ctrl(1), 32'd3);
        repeat (1100) @(negedge clk);
        rd_chk("R9 saturated", a_cnt(1), CMAX);
        rd_chk("R6 upper bits zero", a_cnt(1), CMAX);
        repeat (5) @(negedge clk);
        rd_chk("R9 still saturated", a_cnt(1), CMAX);
        chk("R10 other slot no status", {31'd0, irq}, 32'd0);
        wr(a_ctrl(1), 32'd0);
    endtask

    task automatic t_status();
        wr(a_thr(0), 32'd20);
        wr(a_ctrl(0), 32'd3);
        repeat (19) @(negedge clk);
        rd_chk("R10 below threshold", STAT, 32'd0);
        @(negedge clk);
        chk("R10 irq at threshold", {31'd0, irq}, 32'd1);
        rd_chk("R10 status read", STAT, 32'd1);
        wr(a_ctrl(0), 32'd0);
        wr(STAT, 32'd0);
        rd_chk("R11 write 0 keeps", STAT, 32'd1);
        wr(STAT, 32'd1);
        rd_chk("R11 write 1 clears", STAT, 32'd0);
        repeat (3) @(negedge clk);
        chk("R10 no retrigger", {31'd0, irq}, 32'd0);
        wr(a_cnt(0), CLR);
        wr(a_thr(0), 32'd3);
        wr(a_ctrl(0), 32'd3);
        repeat (2) @(negedge clk);
        wr(STAT, 32'd1);
        chk("R11 set beats clear", {31'd0, irq}, 32'd1);
        wr(a_ctrl(0), 32'd0);
        wr(STAT, 32'd1);
        chk("R11 cleared", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_map();
        rd_chk("R12 reserved field", 10'h00C, 32'd0);
        rd_chk("R12 gap region", 10'h100, 32'd0);
        rd_chk("R12 absent slot", 10'h080, 32'd0);
        rd_chk("R12 past status", 10'h304, 32'd0);
        wr(a_thr(1), 32'hFFFF_FFFF);
        rd_chk("R12 threshold width", a_thr(1), CMAX);
        wr(a_mask(7), 32'hA5A5_0001);
        rd_chk("R12 mask readback", a_mask(7), 32'hA5A5_0001);
        wr(10'h00C, 32'hFFFF_FFFF);
        rd_chk("R12 unmapped write ctrl", a_ctrl(0), 32'd0);
        rd_chk("R12 unmapped write mask", a_mask(0), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_always();
        t_busy();
        t_stopped();
        t_filter();
        t_clear();
        t_saturate();
        t_status();
        t_map();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule